// File: doc/BRIEF.md
# TFT Panel Sync Timing Generator

This block produces the raster timing for a TFT display panel. From a set of configuration counts it drives the horizontal and vertical sync strobes and a data-enable strobe. It also drives a one-pixel line-end strobe and gates a pixel data bus onto the panel. Two copies of the same four-phase state machine do the work. The horizontal copy steps on every pixel-clock enable. The vertical copy steps once per completed line. Both machines cycle through the states SYNC, BACK, ACTIVE and FRONT. The only transitions are SYNC to BACK, BACK to ACTIVE, ACTIVE to FRONT and FRONT to SYNC. Each transition fires when the phase counter reaches the programmed limit of the current state. A clear transition from any state to SYNC, with the count at zero, fires whenever video enable is low.

The current horizontal and vertical phases are output as 2-bit status codes, together with a line counter. Every strobe and the pixel bus have their own polarity inversion input. Configuration inputs are copied into a shadow register only at a frame boundary, or on any clock while video is disabled. A frame in progress therefore always keeps one set of timing values.

Top module: `lcdt_top`

## Requirements
- R1: Horizontal phases run SYNC, BACK, ACTIVE, FRONT and back to SYNC. With limits hs, hb, ha and hf, the phases last hs+1, hb+1, ha+1 and hf+1 enabled pixel clocks. `hstat` reports them as 0=SYNC, 1=BACK, 2=ACTIVE, 3=FRONT.
- R2: The vertical phase uses the same order and the same 0..3 encoding on `vstat`. It advances only on the last pixel clock of a horizontal FRONT phase. The phases last vs+1, vb+1, va+1 and vf+1 lines.
- R3: State advances only on clock edges where `pix_ce` is 1. On other edges every output that depends on state holds its value.
- R4: Before inversion, `hsync` is 1 exactly while the horizontal phase is SYNC, and `vsync` is 1 exactly while the vertical phase is SYNC.
- R5: Before inversion, `den` is 1 only when both the horizontal and the vertical phase are ACTIVE.
- R6: Before inversion, `lend` is 1 for the single pixel period that is the last pixel of the horizontal ACTIVE phase. It is 1 only when `lend_en` is 1, and it is driven on every line.
- R7: Each of `inv_hsync`, `inv_vsync`, `inv_den`, `inv_lend` and `inv_pix` inverts its own output and no other.
- R8: Before inversion, `pix_out` equals `pix_in` while `den` is asserted and is all zeros otherwise.
- R9: While `video_en` is 0, `hsync`, `vsync`, `den`, `lend` and `pix_out` sit at their inactive levels, which are the inversion input values, in the same cycle. From the next clock, both phases are SYNC at count 0 and `line_cnt` is 0.
- R10: `line_cnt` counts completed lines since the start of the current frame, modulo 1024. It returns to 0 at each frame boundary.
- R11: The configuration inputs are sampled on the clock edge that ends the last line of vertical FRONT, and on every edge while `video_en` is 0. A change in the middle of a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_ce | input | 1 | Pixel clock enable |
| video_en | input | 1 | Enables timing output; 0 clears the raster position |
| lend_en | input | 1 | Enables the line-end strobe |
| cfg_hsync_w | input | 8 | Horizontal sync width minus one, in pixels |
| cfg_hback | input | 7 | Horizontal back porch minus one, in pixels |
| cfg_hactive | input | 11 | Active pixels per line minus one |
| cfg_hfront | input | 8 | Horizontal front porch minus one, in pixels |
| cfg_vsync_w | input | 6 | Vertical sync width minus one, in lines |
| cfg_vback | input | 8 | Vertical back porch minus one, in lines |
| cfg_vactive | input | 10 | Active lines per frame minus one |
| cfg_vfront | input | 8 | Vertical front porch minus one, in lines |
| inv_hsync | input | 1 | Invert hsync |
| inv_vsync | input | 1 | Invert vsync |
| inv_den | input | 1 | Invert den |
| inv_lend | input | 1 | Invert lend |
| inv_pix | input | 1 | Invert pix_out |
| pix_in | input | 24 | Pixel data to be gated onto the panel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| den | output | 1 | Data enable |
| lend | output | 1 | Line-end strobe |
| pix_out | output | 24 | Gated pixel data |
| hstat | output | 2 | Horizontal phase code |
| vstat | output | 2 | Vertical phase code |
| line_cnt | output | 10 | Lines since frame start |

## Verification
A wrong horizontal count or state appears on `hstat` and `hsync` in the same cycle. It appears on `den` and `lend` within one line. A vertical fault appears on `vstat`, `vsync` or `line_cnt` at the next line boundary. A shadow register that loads at the wrong time shows up as a changed line length or frame height. That change is visible partway through the frame where configuration was altered, and not only from the following frame. The bench tracks the raster position with a frame-relative pixel index and derives every output from it arithmetically. Any such divergence is therefore reported in the cycle where it first reaches a port.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    typedef enum logic [1:0] {
        PH_SYNC   = 2'd0,
        PH_BACK   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_FRONT  = 2'd3
    } phase_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lcdt_phase_seq.sv
module lcdt_phase_seq
    import lcdt_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] lim_sync,
    input  logic [CNT_W-1:0] lim_back,
    input  logic [CNT_W-1:0] lim_act,
    input  logic [CNT_W-1:0] lim_front,
    output phase_e           phase_o,
    output logic             last_o,
    output logic             wrap_o
);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lim;

    // limit of the state currently held
    always_comb begin
        unique case (ph_q)
            PH_SYNC:   lim = lim_sync;
            PH_BACK:   lim = lim_back;
            PH_ACTIVE: lim = lim_act;
            PH_FRONT:  lim = lim_front;
        endcase
    end

    // next-state logic
    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        if (clr) begin
            ph_d  = PH_SYNC;
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q == lim) begin
                cnt_d = '0;
                unique case (ph_q)
                    PH_SYNC:   ph_d = PH_BACK;
                    PH_BACK:   ph_d = PH_ACTIVE;
                    PH_ACTIVE: ph_d = PH_FRONT;
                    PH_FRONT:  ph_d = PH_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_SYNC;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        phase_o = ph_q;
        last_o  = (cnt_q == lim);
        wrap_o  = step && !clr && last_o && (ph_q == PH_FRONT);
    end

    // R1 / R2: a completed phase moves to the following one
    p_phase_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step && last_o) |=> (phase_o == phase_e'(2'($past(phase_o) + 2'd1))));

    // R3: no step, no movement
    p_hold_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step) |=> ($stable(phase_o) && $stable(cnt_q)));

    // R9: clear returns to the start of sync
    p_clear_to_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ((phase_o == PH_SYNC) && (cnt_q == '0)));

endmodule

// File: rtl/lcdt_cfg_shadow.sv
module lcdt_cfg_shadow #(
    parameter int W = 66
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R11: shadow is frozen between frame boundaries
    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/lcdt_top.sv
module lcdt_top
    import lcdt_pkg::*;
#(
    parameter int HSW_W  = 8,
    parameter int HBP_W  = 7,
    parameter int HACT_W = 11,
    parameter int HFP_W  = 8,
    parameter int VSW_W  = 6,
    parameter int VBP_W  = 8,
    parameter int VACT_W = 10,
    parameter int VFP_W  = 8,
    parameter int LINE_W = 10,
    parameter int PIX_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_ce,
    input  logic              video_en,
    input  logic              lend_en,
    input  logic [HSW_W-1:0]  cfg_hsync_w,
    input  logic [HBP_W-1:0]  cfg_hback,
    input  logic [HACT_W-1:0] cfg_hactive,
    input  logic [HFP_W-1:0]  cfg_hfront,
    input  logic [VSW_W-1:0]  cfg_vsync_w,
    input  logic [VBP_W-1:0]  cfg_vback,
    input  logic [VACT_W-1:0] cfg_vactive,
    input  logic [VFP_W-1:0]  cfg_vfront,
    input  logic              inv_hsync,
    input  logic              inv_vsync,
    input  logic              inv_den,
    input  logic              inv_lend,
    input  logic              inv_pix,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              hsync,
    output logic              vsync,
    output logic              den,
    output logic              lend,
    output logic [PIX_W-1:0]  pix_out,
    output logic [1:0]        hstat,
    output logic [1:0]        vstat,
    output logic [LINE_W-1:0] line_cnt
);

    localparam int HCNT_W = max4(HSW_W, HBP_W, HACT_W, HFP_W);
    localparam int VCNT_W = max4(VSW_W, VBP_W, VACT_W, VFP_W);
    localparam int CFG_W  = HSW_W + HBP_W + HACT_W + HFP_W
                          + VSW_W + VBP_W + VACT_W + VFP_W;

    logic [CFG_W-1:0]  sh_q;
    logic [HSW_W-1:0]  sh_hs;
    logic [HBP_W-1:0]  sh_hb;
    logic [HACT_W-1:0] sh_ha;
    logic [HFP_W-1:0]  sh_hf;
    logic [VSW_W-1:0]  sh_vs;
    logic [VBP_W-1:0]  sh_vb;
    logic [VACT_W-1:0] sh_va;
    logic [VFP_W-1:0]  sh_vf;

    phase_e h_ph, v_ph;
    logic   h_last, h_wrap, v_last, v_wrap;
    logic   clr, frame_end;
    logic   hs_act, vs_act, den_act, lend_act;
    logic [LINE_W-1:0] line_q;

    assign clr       = !video_en;
    assign frame_end = v_wrap;

    lcdt_cfg_shadow #(.W(CFG_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (clr || frame_end),
        .d     ({cfg_hsync_w, cfg_hback, cfg_hactive, cfg_hfront,
                 cfg_vsync_w, cfg_vback, cfg_vactive, cfg_vfront}),
        .q     (sh_q)
    );

    assign {sh_hs, sh_hb, sh_ha, sh_hf, sh_vs, sh_vb, sh_va, sh_vf} = sh_q;

    lcdt_phase_seq #(.CNT_W(HCNT_W)) u_hseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (pix_ce),
        .lim_sync  (HCNT_W'(sh_hs)),
        .lim_back  (HCNT_W'(sh_hb)),
        .lim_act   (HCNT_W'(sh_ha)),
        .lim_front (HCNT_W'(sh_hf)),
        .phase_o   (h_ph),
        .last_o    (h_last),
        .wrap_o    (h_wrap)
    );

    lcdt_phase_seq #(.CNT_W(VCNT_W)) u_vseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .step      (h_wrap),
        .lim_sync  (VCNT_W'(sh_vs)),
        .lim_back  (VCNT_W'(sh_vb)),
        .lim_act   (VCNT_W'(sh_va)),
        .lim_front (VCNT_W'(sh_vf)),
        .phase_o   (v_ph),
        .last_o    (v_last),
        .wrap_o    (v_wrap)
    );

    // line counter register
    always_ff @(posedge clk) begin
        if (!rst_n || clr || frame_end)
            line_q <= '0;
        else if (h_wrap)
            line_q <= line_q + 1'b1;
    end

    // output stage: raw strobes, then polarity
    always_comb begin
        hs_act   = video_en && (h_ph == PH_SYNC);
        vs_act   = video_en && (v_ph == PH_SYNC);
        den_act  = video_en && (h_ph == PH_ACTIVE) && (v_ph == PH_ACTIVE);
        lend_act = video_en && lend_en && (h_ph == PH_ACTIVE) && h_last;
        hsync    = hs_act   ^ inv_hsync;
        vsync    = vs_act   ^ inv_vsync;
        den      = den_act  ^ inv_den;
        lend     = lend_act ^ inv_lend;
        pix_out  = (den_act ? pix_in : '0) ^ {PIX_W{inv_pix}};
        hstat    = h_ph;
        vstat    = v_ph;
        line_cnt = line_q;
    end

    // R2: vertical phase changes only after a completed line
    p_vert_on_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(video_en) && (v_ph != $past(v_ph))) |-> $past(h_wrap));

    // R5: data enable only inside the active window
    p_den_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && (den != inv_den)) |-> ((hstat == 2'd2) && (vstat == 2'd2)));

    // R6: line-end strobe lasts a single pixel period
    p_lend_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lend_act && pix_ce) |=> !lend_act);

    // R9: disabled output sits at inactive levels
    p_idle_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !video_en |-> ((hsync == inv_hsync) && (vsync == inv_vsync)
                       && (den == inv_den) && (lend == inv_lend)));

    // R10: line counter restarts at frame boundary
    p_line_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && frame_end) |=> (line_cnt == '0));

    // v_last is observed only through wrap_o of the vertical sequencer
    logic unused_ok;
    assign unused_ok = v_last;

endmodule

// File: tb/lcdt_top_test.sv
module lcdt_top_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, pix_ce, video_en, lend_en;
    logic [7:0]  cfg_hsync_w;
    logic [6:0]  cfg_hback;
    logic [10:0] cfg_hactive;
    logic [7:0]  cfg_hfront;
    logic [5:0]  cfg_vsync_w;
    logic [7:0]  cfg_vback;
    logic [9:0]  cfg_vactive;
    logic [7:0]  cfg_vfront;
    logic        inv_hsync, inv_vsync, inv_den, inv_lend, inv_pix;
    logic [23:0] pix_in;
    logic        hsync, vsync, den, lend;
    logic [23:0] pix_out;
    logic [1:0]  hstat, vstat;
    logic [9:0]  line_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdt_top uut (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .video_en(video_en), .lend_en(lend_en),
        .cfg_hsync_w(cfg_hsync_w), .cfg_hback(cfg_hback), .cfg_hactive(cfg_hactive),
        .cfg_hfront(cfg_hfront), .cfg_vsync_w(cfg_vsync_w), .cfg_vback(cfg_vback),
        .cfg_vactive(cfg_vactive), .cfg_vfront(cfg_vfront),
        .inv_hsync(inv_hsync), .inv_vsync(inv_vsync), .inv_den(inv_den),
        .inv_lend(inv_lend), .inv_pix(inv_pix), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .den(den), .lend(lend), .pix_out(pix_out),
        .hstat(hstat), .vstat(vstat), .line_cnt(line_cnt)
    );

    typedef struct {
        logic        hs, vs, de, le;
        logic [1:0]  hst, vst;
        logic [9:0]  lc;
        logic [23:0] pd;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    fails  = 0;
    string scen   = "reset";

    // model state: frame-relative pixel index and the timing it runs with
    int idx = 0;
    int c_hs, c_hb, c_ha, c_hf, c_vs, c_vb, c_va, c_vf;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, scen, act, exp, $time);
        end
    endtask

    function automatic int line_len();
        return c_hs + c_hb + c_ha + c_hf + 4;
    endfunction

    function automatic int frame_len();
        return line_len() * (c_vs + c_vb + c_va + c_vf + 4);
    endfunction

    task automatic load_cur();
        c_hs = cfg_hsync_w; c_hb = cfg_hback; c_ha = cfg_hactive; c_hf = cfg_hfront;
        c_vs = cfg_vsync_w; c_vb = cfg_vback; c_va = cfg_vactive; c_vf = cfg_vfront;
    endtask

    function automatic exp_t model();
        exp_t e;
        int ln, px, hp, vp;
        logic de_raw;
        ln = idx / line_len();
        px = idx % line_len();
        hp = (px <= c_hs) ? 0 : (px <= c_hs + c_hb + 1) ? 1 :
             (px <= c_hs + c_hb + c_ha + 2) ? 2 : 3;
        vp = (ln <= c_vs) ? 0 : (ln <= c_vs + c_vb + 1) ? 1 :
             (ln <= c_vs + c_vb + c_va + 2) ? 2 : 3;
        de_raw = video_en && (hp == 2) && (vp == 2);
        e.hst = 2'(hp);
        e.vst = 2'(vp);
        e.hs  = (video_en && hp == 0) ^ inv_hsync;
        e.vs  = (video_en && vp == 0) ^ inv_vsync;
        e.de  = de_raw ^ inv_den;
        e.le  = (video_en && lend_en && hp == 2 && px == c_hs + c_hb + c_ha + 2) ^ inv_lend;
        e.lc  = 10'(ln % 1024);
        e.pd  = (de_raw ? pix_in : 24'h0) ^ {24{inv_pix}};
        return e;
    endfunction

    // driver: push the expectation for this cycle, then advance the model at the edge
    task automatic tick();
        pix_in = pix_in + 24'h010203;
        #0;
        sb.push_back(model());
        @(posedge clk);
        if (!video_en) begin
            idx = 0;
            load_cur();
        end else if (pix_ce) begin
            idx++;
            if (idx == frame_len()) begin
                idx = 0;
                load_cur();
            end
        end
        #1;
    endtask

    task automatic run(input int n, input bit alt);
        for (int i = 0; i < n; i++) begin
            pix_ce = alt ? i[0] : 1'b1;
            tick();
        end
    endtask

    // monitor: pop and compare at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk("R1 hstat",    32'(hstat),    32'(e.hst));
            chk("R2 vstat",    32'(vstat),    32'(e.vst));
            chk("R4 hsync",    32'(hsync),    32'(e.hs));
            chk("R4 vsync",    32'(vsync),    32'(e.vs));
            chk("R5 den",      32'(den),      32'(e.de));
            chk("R6 lend",     32'(lend),     32'(e.le));
            chk("R10 line",    32'(line_cnt), 32'(e.lc));
            chk("R8 pix_out",  32'(pix_out),  32'(e.pd));
        end
    end

    task automatic set_cfg(input int hs, hb, ha, hf, vs, vb, va, vf);
        cfg_hsync_w = 8'(hs); cfg_hback = 7'(hb); cfg_hactive = 11'(ha); cfg_hfront = 8'(hf);
        cfg_vsync_w = 6'(vs); cfg_vback = 8'(vb); cfg_vactive = 10'(va); cfg_vfront = 8'(vf);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired [%s] actual=running expected=done", scen);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pix_ce = 1'b0; video_en = 1'b0; lend_en = 1'b1;
        inv_hsync = 1'b0; inv_vsync = 1'b0; inv_den = 1'b0; inv_lend = 1'b0; inv_pix = 1'b0;
        pix_in = 24'h0;
        set_cfg(1, 2, 3, 1, 0, 1, 2, 0);
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state, outputs inactive
        chk("R9 reset hstat", 32'(hstat), 0);
        chk("R9 reset vstat", 32'(vstat), 0);
        chk("R9 reset line",  32'(line_cnt), 0);
        chk("R9 reset hsync", 32'(hsync), 0);
        chk("R9 reset den",   32'(den), 0);
        chk("R9 reset pix",   32'(pix_out), 0);
        rst_n = 1'b1;
        load_cur();
        run(2, 0);

        // R1 R2 R4 R5 R6 R10: two full frames, continuous pixel enable
        scen = "R1 continuous";
        video_en = 1'b1;
        run(2 * 77 + 5, 0);

        // R3: pixel enable every other clock
        scen = "R3 gapped";
        run(170, 1);

        // R7: every polarity inverted
        scen = "R7 inverted";
        inv_hsync = 1'b1; inv_vsync = 1'b1; inv_den = 1'b1; inv_lend = 1'b1; inv_pix = 1'b1;
        run(40, 0);
        inv_hsync = 1'b0; inv_lend = 1'b0;
        run(30, 0);
        inv_vsync = 1'b0; inv_den = 1'b0; inv_pix = 1'b0;

        // R6: line-end strobe disabled
        scen = "R6 lend off";
        lend_en = 1'b0;
        run(30, 0);
        lend_en = 1'b1;

        // R11: change timing in mid-frame, old frame must finish unchanged
        scen = "R11 midframe";
        run(20, 0);
        set_cfg(0, 0, 5, 2, 1, 0, 1, 1);
        run(200, 0);

        // R9: disable in mid-frame, then restart
        scen = "R9 disable";
        run(13, 0);
        video_en = 1'b0;
        tick();
        tick();
        chk("R9 cleared hstat", 32'(hstat), 0);
        chk("R9 cleared vstat", 32'(vstat), 0);
        chk("R9 cleared line",  32'(line_cnt), 0);
        chk("R9 idle hsync",    32'(hsync), 0);
        video_en = 1'b1;
        run(60, 0);

        // R10: a tall frame makes the line counter wrap at 1024
        scen = "R10 wrap";
        video_en = 1'b0;
        set_cfg(0, 0, 0, 0, 0, 0, 1023, 7);
        tick();
        video_en = 1'b1;
        run(4200, 0);

        @(negedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule